// File: doc/BRIEF.md
# Comma aligner with polarity detection

This block sits behind the deserializer of a serial lane receiver. It takes raw 10-bit words whose boundaries are arbitrary with respect to the encoded symbols. It searches every bit offset for the K28.5 comma, in either running-disparity form. Once it has found the comma it holds that offset and presents aligned 10-bit symbols with a valid flag. It raises a lock flag after repeated commas at the held offset. It drops the lock when the commas stop arriving at that offset.

While locked, the block also watches the identifier field of each training set. If that field shows the bit complement of the expected alternating pattern, the lane's differential pair is taken to be swapped. The block then sets its inversion flag and complements every output symbol. Comma search always runs on the uninverted stream, because complementing a comma only turns it into its other disparity form. A change of polarity at run time therefore never disturbs the alignment.

Top module: `comma_align_pol`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `locked`, `pol_inv`, `sym_vld` and `comma_pulse` are 0.
- R2: The raw stream is read with `raw_in[9]` as the earliest bit. The commas are 0011111010 and 1100000101, each written earliest bit first. Either form is found at any of the 10 bit slips 0 to 9. In the cycle after the word that completes a comma, `comma_pulse` is 1, and `sym_out` shows the comma whenever `sym_vld` is 1.
- R3: `locked` rises in the cycle after the word that completes the third comma at the held offset (LOCK_COMMAS = 3), and never earlier. `sym_vld` is 1 only while `locked` is 1.
- R4: The first comma found fixes the offset. While that offset is held, commas at any other offset produce no `comma_pulse` and do not count toward lock.
- R5: After LOSS_LIMIT consecutive valid words without a comma at the held offset, `locked` drops and the offset is released. The next comma at any offset is then acquired again.
- R6: A one-cycle `realign` clears lock and releases the offset. In the following cycle `locked`, `sym_vld` and `comma_pulse` are 0.
- R7: While locked, each output symbol equals the wire symbol at the held offset. When `pol_inv` is 1, the symbol is bit-complemented.
- R8: Symbol positions are counted from the comma, which is position 0. If, while locked, all ten symbols at positions 6 to 15 are 1010101010 (the complement of D10.2), `pol_inv` becomes 1. If all ten are 0101010101 (D10.2), `pol_inv` becomes 0. The new value applies from the deciding symbol on.
- R9: If the ten identifier positions do not all agree, `pol_inv` keeps its value.
- R10: A change of `pol_inv` happens only while locked. It causes no loss of lock and no change of alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_in | input | 10 | Raw deserialized word, bit 9 earliest on the wire |
| raw_vld | input | 1 | `raw_in` holds a new word this cycle |
| realign | input | 1 | Release the held offset and restart the search |
| sym_out | output | 10 | Aligned symbol, complemented when `pol_inv` is set |
| sym_vld | output | 1 | `sym_out` carries a new symbol while locked |
| locked | output | 1 | Alignment is locked |
| pol_inv | output | 1 | Lane polarity is treated as swapped |
| comma_pulse | output | 1 | A comma was accepted in the word just presented |

## Verification
The assertions watch the properties that can be checked cycle by cycle on every cycle:
- outputs are quiet during reset and after a realign;
- lock only rises on an accepted comma;
- any comma shown on a valid output has one of the two comma forms;
- polarity changes only on a valid, locked, non-comma symbol;
- a loss of lock never coincides with an accepted comma.

The following can only be shown by the bench's scenarios, because they depend on the stream the bench builds:
- lock on exactly the third comma at each of the ten slips and both disparities;
- the exact symbol sequence after lock;
- the polarity decision from a complemented stream, including corrected D10.2 symbols afterwards;
- polarity left alone for mixed identifiers;
- commas at a shifted offset being ignored until lock drops after exactly LOSS_LIMIT words.

// File: rtl/comma_align_pol.sv
module comma_align_pol #(
  parameter int LOCK_COMMAS = 3,
  parameter int LOSS_LIMIT  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [9:0] raw_in,
  input  logic       raw_vld,
  input  logic       realign,
  output logic [9:0] sym_out,
  output logic       sym_vld,
  output logic       locked,
  output logic       pol_inv,
  output logic       comma_pulse
);
  localparam int SW = 10;
  localparam int CW = $clog2(LOCK_COMMAS + 1);
  localparam int MW = $clog2(LOSS_LIMIT + 1);
  localparam logic [SW-1:0] K_NEG   = 10'b0011111010;
  localparam logic [SW-1:0] K_POS   = ~K_NEG;
  localparam logic [SW-1:0] ID_OK   = 10'b0101010101;
  localparam logic [SW-1:0] ID_SWAP = ~ID_OK;

  logic [SW-1:0]   hist;
  logic [2*SW-1:0] cat;
  logic [SW-1:0]   cand [SW];
  logic [SW-1:0]   hit;
  assign cat = {hist, raw_in};

  generate
    for (genvar k = 0; k < SW; k++) begin : g_ofs
      assign cand[k] = cat[2*SW-1-k -: SW];
      assign hit[k]  = (cand[k] == K_NEG) || (cand[k] == K_POS);
    end
  endgenerate

  logic [3:0]    ofs, ofs_n, first_k, sel;
  logic [CW-1:0] cnt, cnt_n;
  logic [MW-1:0] miss, miss_n;
  logic [4:0]    pos, pos_n, pos_cur;
  logic          locked_n, inv_n, id_ok, id_sw, id_ok_n, id_sw_n;

  always_comb begin
    first_k = '0;
    for (int k = SW - 1; k >= 0; k--)
      if (hit[k]) first_k = 4'(k);
  end

  wire          held     = (cnt != '0);
  assign        sel      = held ? ofs : first_k;
  wire [SW-1:0] sym_raw  = cand[sel];
  wire          com_here = held ? hit[ofs] : |hit;
  wire          take     = raw_vld && !realign;

  always_comb begin
    cnt_n    = cnt;
    locked_n = locked;
    miss_n   = miss;
    ofs_n    = ofs;
    if (realign) begin
      cnt_n    = '0;
      locked_n = 1'b0;
      miss_n   = '0;
    end else if (raw_vld) begin
      if (com_here) begin
        ofs_n  = sel;
        miss_n = '0;
        if (cnt != CW'(LOCK_COMMAS)) cnt_n = cnt + CW'(1);
        if (cnt >= CW'(LOCK_COMMAS - 1)) locked_n = 1'b1;
      end else if (held) begin
        if (miss == MW'(LOSS_LIMIT - 1)) begin
          cnt_n    = '0;
          locked_n = 1'b0;
          miss_n   = '0;
        end else begin
          miss_n = miss + MW'(1);
        end
      end
    end
  end

  assign pos_cur = com_here ? 5'd0 : ((pos == 5'd16) ? 5'd16 : pos + 5'd1);
  wire is_ok  = (sym_raw == ID_OK);
  wire is_sw  = (sym_raw == ID_SWAP);
  wire in_id  = (pos_cur >= 5'd6) && (pos_cur <= 5'd15);
  wire all_ok = ((pos_cur == 5'd6) ? 1'b1 : id_ok) && is_ok;
  wire all_sw = ((pos_cur == 5'd6) ? 1'b1 : id_sw) && is_sw;

  always_comb begin
    pos_n   = pos;
    id_ok_n = id_ok;
    id_sw_n = id_sw;
    inv_n   = pol_inv;
    if (realign) pos_n = 5'd16;
    else if (raw_vld) pos_n = pos_cur;
    if (take && in_id) begin
      id_ok_n = all_ok;
      id_sw_n = all_sw;
    end
    if (take && locked_n && pos_cur == 5'd15) begin
      if (all_ok) inv_n = 1'b0;
      else if (all_sw) inv_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist        <= '0;
      ofs         <= '0;
      cnt         <= '0;
      miss        <= '0;
      locked      <= 1'b0;
      pos         <= 5'd16;
      id_ok       <= 1'b0;
      id_sw       <= 1'b0;
      pol_inv     <= 1'b0;
      sym_out     <= '0;
      sym_vld     <= 1'b0;
      comma_pulse <= 1'b0;
    end else begin
      if (raw_vld) hist <= raw_in;
      ofs         <= ofs_n;
      cnt         <= cnt_n;
      miss        <= miss_n;
      locked      <= locked_n;
      pos         <= pos_n;
      id_ok       <= id_ok_n;
      id_sw       <= id_sw_n;
      pol_inv     <= inv_n;
      sym_vld     <= take && locked_n;
      comma_pulse <= take && com_here;
      if (take) sym_out <= sym_raw ^ {SW{inv_n}};
    end
  end
endmodule

// File: rtl/comma_align_pol_chk.sv
module comma_align_pol_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       realign,
  input logic [9:0] sym_out,
  input logic       sym_vld,
  input logic       locked,
  input logic       pol_inv,
  input logic       comma_pulse
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!locked && !sym_vld && !comma_pulse && !pol_inv));

  a_r2_comma_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (comma_pulse && sym_vld) |-> (sym_out == 10'b0011111010 || sym_out == 10'b1100000101));

  a_r3_lock_on_comma: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (comma_pulse && sym_vld));

  a_r5_drop_no_comma: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> !comma_pulse);

  a_r6_realign_clears: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> (!locked && !sym_vld && !comma_pulse));

  a_r10_flip_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pol_inv) |-> (locked && sym_vld && !comma_pulse));
endmodule

bind comma_align_pol comma_align_pol_chk u_chk (.*);

// File: tb/sim_comma_align_pol.sv
module sim_comma_align_pol;
  localparam int LOSS = 32;
  localparam logic [9:0] KN   = 10'b0011111010;
  localparam logic [9:0] KP   = 10'b1100000101;
  localparam logic [9:0] D10  = 10'b0101010101;
  localparam logic [9:0] D21  = 10'b1010101010;
  localparam logic [9:0] FILL = 10'b1001011100;

  logic clk = 1'b0;
  always #4 clk = ~clk;
  logic rst_n = 1'b0, raw_vld = 1'b0, realign = 1'b0;
  logic [9:0] raw_in = '0;
  logic [9:0] sym_out;
  logic sym_vld, locked, pol_inv, comma_pulse;

  comma_align_pol #(.LOCK_COMMAS(3), .LOSS_LIMIT(LOSS)) u0 (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .raw_vld(raw_vld), .realign(realign),
    .sym_out(sym_out), .sym_vld(sym_vld), .locked(locked), .pol_inv(pol_inv),
    .comma_pulse(comma_pulse));

  int nchk = 0, nerr = 0;
  logic bitbuf [0:4095];
  logic [9:0] wsym [0:255];
  int nb, rb, ns;
  int npulse, since, lock_pulse, ndrop, drop_since, pulse_at_drop;
  int mism, sidx, nfix, nbad, nvld_bad;
  bit seq_on, was_locked;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_stream();
    nb = 0; rb = 0; ns = 0;
  endtask

  task automatic push_junk(input int n);
    for (int i = 0; i < n; i++) begin bitbuf[nb] = (i % 2 == 0); nb++; end
  endtask

  task automatic push_sym(input logic [9:0] s);
    wsym[ns] = s; ns++;
    for (int i = 9; i >= 0; i--) begin bitbuf[nb] = s[i]; nb++; end
  endtask

  task automatic push_frame(input logic [9:0] com, input logic [9:0] ida,
                            input logic [9:0] idb, input bit swap);
    push_sym(com ^ {10{swap}});
    for (int i = 0; i < 5; i++) push_sym(FILL ^ {10{swap}});
    for (int i = 0; i < 5; i++) push_sym(ida ^ {10{swap}});
    for (int i = 0; i < 5; i++) push_sym(idb ^ {10{swap}});
  endtask

  task automatic reset_trk(input bit seq);
    npulse = 0; since = 0; lock_pulse = -1; ndrop = 0; drop_since = -1; pulse_at_drop = -1;
    mism = 0; sidx = 32; nfix = 0; nbad = 0; nvld_bad = 0; seq_on = seq; was_locked = locked;
  endtask

  task automatic observe();
    if (comma_pulse) begin npulse++; since = 0; end else since++;
    if (locked && !was_locked && lock_pulse < 0) lock_pulse = npulse;
    if (!locked && was_locked) begin ndrop++; drop_since = since; pulse_at_drop = npulse; end
    if (sym_vld && seq_on) begin
      if (sym_out != (wsym[sidx] ^ {10{pol_inv}})) mism++;
      sidx++;
    end
    if (sym_vld && pol_inv && sym_out == D10) nfix++;
    if (sym_vld && pol_inv && sym_out == D21) nbad++;
    if (sym_vld && !locked) nvld_bad++;
    was_locked = locked;
  endtask

  task automatic send_word();
    logic [9:0] w;
    for (int i = 0; i < 10; i++) w[9-i] = bitbuf[rb+i];
    rb += 10;
    raw_in = w; raw_vld = 1'b1;
    @(negedge clk);
    observe();
  endtask

  task automatic send_all();
    while (rb + 10 <= nb) send_word();
    raw_vld = 1'b0;
  endtask

  task automatic do_realign();
    raw_vld = 1'b0; realign = 1'b1;
    @(negedge clk);
    realign = 1'b0;
    was_locked = locked;
  endtask

  task automatic t_reset();
    chk(locked == 1'b0, "R1 locked after reset", locked, 0);
    chk(pol_inv == 1'b0, "R1 pol_inv after reset", pol_inv, 0);
    chk(sym_vld == 1'b0, "R1 sym_vld after reset", sym_vld, 0);
    chk(comma_pulse == 1'b0, "R1 comma_pulse after reset", comma_pulse, 0);
  endtask

  task automatic t_slip(input int slip, input bit neg);
    do_realign();
    clear_stream();
    push_junk(slip);
    for (int f = 0; f < 4; f++) push_frame(neg ? KN : KP, D10, D10, 1'b0);
    push_sym(D10);
    reset_trk(1'b1);
    send_all();
    chk(npulse == 4, $sformatf("R2 commas found slip %0d neg %0d", slip, neg), npulse, 4);
    chk(lock_pulse == 3, $sformatf("R3 lock on third comma slip %0d", slip), lock_pulse, 3);
    chk(nvld_bad == 0, "R3 sym_vld only when locked", nvld_bad, 0);
    chk(mism == 0, $sformatf("R7 aligned sequence slip %0d", slip), mism, 0);
    chk(pol_inv == 1'b0, "R8 polarity stays normal on D10.2", pol_inv, 0);
  endtask

  task automatic t_swap();
    do_realign();
    clear_stream();
    push_junk(4);
    for (int f = 0; f < 4; f++) push_frame(KN, D10, D10, 1'b1);
    push_sym(D21);
    reset_trk(1'b1);
    send_all();
    chk(pol_inv == 1'b1, "R8 swapped pair sets pol_inv", pol_inv, 1);
    chk(nfix >= 10, "R8 corrected D10.2 after inversion", nfix, 10);
    chk(nbad == 0, "R8 no complemented id after inversion", nbad, 0);
    chk(mism == 0, "R7 sequence with inversion", mism, 0);
    chk(ndrop == 0 && locked, "R10 lock kept across polarity change", ndrop, 0);
  endtask

  task automatic t_mixed();
    do_realign();
    clear_stream();
    push_junk(6);
    for (int f = 0; f < 4; f++) push_frame(KP, D21, D10, 1'b0);
    push_sym(D10);
    reset_trk(1'b1);
    send_all();
    chk(pol_inv == 1'b1, "R9 mixed ids keep polarity", pol_inv, 1);
    chk(lock_pulse == 3, "R9 lock on mixed stream", lock_pulse, 3);
    chk(mism == 0, "R7 sequence on mixed stream", mism, 0);
  endtask

  task automatic t_restore();
    do_realign();
    clear_stream();
    push_junk(1);
    for (int f = 0; f < 4; f++) push_frame(KN, D10, D10, 1'b0);
    push_sym(D10);
    reset_trk(1'b1);
    send_all();
    chk(pol_inv == 1'b0, "R8 normal ids clear pol_inv", pol_inv, 0);
    chk(mism == 0, "R7 sequence after restore", mism, 0);
    chk(ndrop == 0, "R10 no lock loss on restore", ndrop, 0);
  endtask

  task automatic t_shift();
    do_realign();
    clear_stream();
    push_junk(2);
    for (int f = 0; f < 4; f++) push_frame(KN, D10, D10, 1'b0);
    push_junk(3);
    for (int f = 0; f < 4; f++) push_frame(KN, D10, D10, 1'b0);
    push_sym(D10);
    reset_trk(1'b0);
    send_all();
    chk(lock_pulse == 3, "R3 lock before shift", lock_pulse, 3);
    chk(pulse_at_drop == 4, "R4 shifted commas ignored while held", pulse_at_drop, 4);
    chk(drop_since == LOSS, "R5 lock drops after LOSS_LIMIT misses", drop_since, LOSS);
    chk(ndrop == 1, "R5 single lock loss", ndrop, 1);
    chk(npulse > 4, "R5 reacquire after loss", npulse, 5);
  endtask

  task automatic t_realign();
    int pre;
    do_realign();
    clear_stream();
    push_junk(7);
    for (int f = 0; f < 7; f++) push_frame(KP, D10, D10, 1'b0);
    push_sym(D10);
    reset_trk(1'b0);
    while (!locked && rb + 10 <= nb) send_word();
    raw_vld = 1'b0;
    chk(locked == 1'b1, "R3 locked before realign", locked, 1);
    do_realign();
    chk(locked == 1'b0, "R6 realign clears lock", locked, 0);
    chk(sym_vld == 1'b0, "R6 no valid symbol after realign", sym_vld, 0);
    pre = npulse;
    lock_pulse = -1;
    send_all();
    chk(lock_pulse == pre + 3, "R6 relock after three commas", lock_pulse, pre + 3);
    chk(nvld_bad == 0, "R3 sym_vld only when locked after realign", nvld_bad, 0);
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    for (int s = 0; s < 10; s++) begin
      t_slip(s, 1'b1);
      t_slip(s, 1'b0);
    end
    t_swap();
    t_mixed();
    t_restore();
    t_shift();
    t_realign();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule